// File: doc/BRIEF.md
# ALU Status Flag Unit

This block keeps the four arithmetic status flags of a small 8-bit processor core (carry/borrow, half carry, zero and negative) and updates them from the operation that the core's decoder selects. A built-in adder/subtractor model produces the result together with the carry out of the top bit and the carry across the nibble boundary. A rotator handles rotate-through-carry, so that several bytes can be shifted as one wide word by chaining the carry from one rotate to the next. Results of logic and data-move operations come from outside the block and are judged for zero and sign.

The decoder drives a one-hot strobe vector, one bit for each operation, and the flag registers commit on the clock edge where that strobe is sampled. The dedicated carry instructions (set, clear, invert, load from a bit, store to a bit) work on the carry flag without the ALU. Set and clear also act on half carry.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all four flags are 0 after that edge.
- R2: Add (strobe bit 0): `res` = `opnd_a + opnd_b` modulo 2^8. C becomes the carry out of bit 7 and H the carry from bit 3 into bit 4.
- R3: Subtract (strobe bit 1): `res` = `opnd_a - opnd_b` modulo 2^8. C becomes 1 exactly when `opnd_a < opnd_b` (unsigned borrow) and H becomes 1 exactly when `opnd_a[3:0] < opnd_b[3:0]` (borrow out of the low nibble).
- R4: Add, subtract, logic (bit 2), move (bit 3), rotate right (bit 9) and rotate left (bit 10) set Z when `res` is all zeros and set N to `res[7]`. Logic and move pass `ext_res` to `res` and leave C and H unchanged.
- R5: Set-carry (bit 4) makes C and H 1. Clear-carry (bit 5) makes C and H 0. Both leave Z and N unchanged.
- R6: Invert-carry (bit 6) toggles C. Load-carry (bit 7) copies `load_bit` into C. Neither changes H, Z or N.
- R7: `store_bit` equals C while the store-carry strobe (bit 8) is high and is 0 otherwise. Store-carry changes no flag.
- R8: Rotate right gives `res = {C, opnd_a[7:1]}` and new C = `opnd_a[0]`. Rotate left gives `res = {opnd_a[6:0], C}` and new C = `opnd_a[7]`. H is unchanged.
- R9: When no strobe bit is set, or more than one is set, no flag changes.
- R10: `res` and `store_bit` follow the strobe within the same cycle. The flags take their new values at the clock edge that samples the strobe and stay stable until the next valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_onehot | input | 11 | One-hot operation strobes (bit positions as in the requirements) |
| opnd_a | input | 8 | Accumulator operand, also the rotate source |
| opnd_b | input | 8 | Second operand of add and subtract |
| ext_res | input | 8 | Result of a logic or move operation computed outside |
| load_bit | input | 1 | Data bit for load-carry |
| res | output | 8 | Result of the current operation |
| store_bit | output | 1 | Carry value presented for store-carry |
| flag_c | output | 1 | Carry/borrow flag |
| flag_h | output | 1 | Half-carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
The bench builds the block with its default parameters: an 8-bit datapath with the half-carry boundary between bits 3 and 4. At that width every operand pair for add fits in a short run, so carry and half carry are compared over the whole 256 by 256 space. A thinned sweep covers subtract, including every borrow and half-borrow boundary. Multi-byte rotates chain the carry across two bytes to show the wide-shift use. The dedicated carry operations and illegal strobe patterns are run against known flag states.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

    localparam int unsigned OP_COUNT = 11;

    localparam int unsigned OP_ADD   = 0;
    localparam int unsigned OP_SUB   = 1;
    localparam int unsigned OP_LOGIC = 2;
    localparam int unsigned OP_MOVE  = 3;
    localparam int unsigned OP_SETC  = 4;
    localparam int unsigned OP_CLRC  = 5;
    localparam int unsigned OP_INVC  = 6;
    localparam int unsigned OP_LDC   = 7;
    localparam int unsigned OP_STC   = 8;
    localparam int unsigned OP_RORC  = 9;
    localparam int unsigned OP_ROLC  = 10;

    typedef enum logic [3:0] {
        OPK_NONE  = 4'd0,
        OPK_ADD   = 4'd1,
        OPK_SUB   = 4'd2,
        OPK_LOGIC = 4'd3,
        OPK_MOVE  = 4'd4,
        OPK_SETC  = 4'd5,
        OPK_CLRC  = 4'd6,
        OPK_INVC  = 4'd7,
        OPK_LDC   = 4'd8,
        OPK_STC   = 4'd9,
        OPK_RORC  = 4'd10,
        OPK_ROLC  = 4'd11
    } op_kind_e;

    typedef struct packed {
        logic c;
        logic h;
        logic z;
        logic n;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{c: 1'b0, h: 1'b0, z: 1'b0, n: 1'b0};

    function automatic flags_t with_zn(flags_t f, logic zero, logic neg);
        flags_t r;
        r   = f;
        r.z = zero;
        r.n = neg;
        return r;
    endfunction

    function automatic flags_t with_ch(flags_t f, logic carry, logic half);
        flags_t r;
        r   = f;
        r.c = carry;
        r.h = half;
        return r;
    endfunction

endpackage

// File: rtl/flag_op_decode.sv
module flag_op_decode
    import flag_unit_pkg::*;
(
    input  logic [OP_COUNT-1:0] op_onehot,
    output op_kind_e            kind
);
    logic single;

    always_comb begin
        single = ($countones(op_onehot) == 1);
        kind   = OPK_NONE;
        if (single) begin
            for (int i = 0; i < int'(OP_COUNT); i++) begin
                if (op_onehot[i]) begin
                    kind = op_kind_e'(4'(i + 1));
                end
            end
        end
    end
endmodule

// File: rtl/flag_arith.sv
module flag_arith #(
    parameter int DATA_W   = 8,
    parameter int NIBBLE_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry_flag,
    output logic              half_flag
);
    localparam int HI_W = DATA_W - NIBBLE_W;

    logic [DATA_W-1:0] b_eff;
    logic [NIBBLE_W:0] lo;
    logic [HI_W:0]     hi;

    always_comb begin
        b_eff = sub ? ~b : b;
        lo    = {1'b0, a[NIBBLE_W-1:0]} + {1'b0, b_eff[NIBBLE_W-1:0]}
              + (NIBBLE_W+1)'(sub);
        hi    = {1'b0, a[DATA_W-1:NIBBLE_W]} + {1'b0, b_eff[DATA_W-1:NIBBLE_W]}
              + (HI_W+1)'(lo[NIBBLE_W]);
        sum   = {hi[HI_W-1:0], lo[NIBBLE_W-1:0]};
        // With inverted operand plus one, a missing carry means a borrow.
        carry_flag = hi[HI_W] ^ sub;
        half_flag  = lo[NIBBLE_W] ^ sub;
    end
endmodule

// File: rtl/flag_rotate.sv
module flag_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    output logic [DATA_W-1:0] res_right,
    output logic              cout_right,
    output logic [DATA_W-1:0] res_left,
    output logic              cout_left
);
    always_comb begin
        res_right  = {cin, a[DATA_W-1:1]};
        cout_right = a[0];
        res_left   = {a[DATA_W-2:0], cin};
        cout_left  = a[DATA_W-1];
    end
endmodule

// File: rtl/flag_next_state.sv
module flag_next_state
    import flag_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_kind_e          kind,
    input  flags_t            cur,
    input  logic [DATA_W-1:0] arith_sum,
    input  logic              arith_c,
    input  logic              arith_h,
    input  logic [DATA_W-1:0] rot_r,
    input  logic              rot_rc,
    input  logic [DATA_W-1:0] rot_l,
    input  logic              rot_lc,
    input  logic [DATA_W-1:0] ext_res,
    input  logic              load_bit,
    output flags_t            nxt,
    output logic [DATA_W-1:0] res,
    output logic              store_bit
);
    logic upd_zn;

    always_comb begin
        nxt       = cur;
        res       = '0;
        store_bit = 1'b0;
        upd_zn    = 1'b0;
        unique case (kind)
            OPK_ADD, OPK_SUB: begin
                res    = arith_sum;
                nxt    = with_ch(cur, arith_c, arith_h);
                upd_zn = 1'b1;
            end
            OPK_LOGIC, OPK_MOVE: begin
                res    = ext_res;
                upd_zn = 1'b1;
            end
            OPK_SETC: nxt = with_ch(cur, 1'b1, 1'b1);
            OPK_CLRC: nxt = with_ch(cur, 1'b0, 1'b0);
            OPK_INVC: nxt.c = ~cur.c;
            OPK_LDC:  nxt.c = load_bit;
            OPK_STC:  store_bit = cur.c;
            OPK_RORC: begin
                res    = rot_r;
                nxt.c  = rot_rc;
                upd_zn = 1'b1;
            end
            OPK_ROLC: begin
                res    = rot_l;
                nxt.c  = rot_lc;
                upd_zn = 1'b1;
            end
            default: ;
        endcase
        if (upd_zn) begin
            nxt = with_zn(nxt, (res == '0), res[DATA_W-1]);
        end
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import flag_unit_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NIBBLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OP_COUNT-1:0] op_onehot,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [DATA_W-1:0]   ext_res,
    input  logic                load_bit,
    output logic [DATA_W-1:0]   res,
    output logic                store_bit,
    output logic                flag_c,
    output logic                flag_h,
    output logic                flag_z,
    output logic                flag_n
);
    op_kind_e          kind;
    flags_t            cur_q;
    flags_t            nxt;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_c;
    logic              arith_h;
    logic [DATA_W-1:0] rot_r;
    logic [DATA_W-1:0] rot_l;
    logic              rot_rc;
    logic              rot_lc;

    flag_op_decode i_decode (
        .op_onehot (op_onehot),
        .kind      (kind)
    );

    flag_arith #(.DATA_W(DATA_W), .NIBBLE_W(NIBBLE_W)) i_arith (
        .a          (opnd_a),
        .b          (opnd_b),
        .sub        (kind == OPK_SUB),
        .sum        (arith_sum),
        .carry_flag (arith_c),
        .half_flag  (arith_h)
    );

    flag_rotate #(.DATA_W(DATA_W)) i_rotate (
        .a          (opnd_a),
        .cin        (cur_q.c),
        .res_right  (rot_r),
        .cout_right (rot_rc),
        .res_left   (rot_l),
        .cout_left  (rot_lc)
    );

    flag_next_state #(.DATA_W(DATA_W)) i_next (
        .kind      (kind),
        .cur       (cur_q),
        .arith_sum (arith_sum),
        .arith_c   (arith_c),
        .arith_h   (arith_h),
        .rot_r     (rot_r),
        .rot_rc    (rot_rc),
        .rot_l     (rot_l),
        .rot_lc    (rot_lc),
        .ext_res   (ext_res),
        .load_bit  (load_bit),
        .nxt       (nxt),
        .res       (res),
        .store_bit (store_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= FLAGS_CLEAR;
        end else begin
            cur_q <= nxt;
        end
    end

    assign flag_c = cur_q.c;
    assign flag_h = cur_q.h;
    assign flag_z = cur_q.z;
    assign flag_n = cur_q.n;
endmodule

// File: rtl/flag_unit_checker.sv
module flag_unit_checker
    import flag_unit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [OP_COUNT-1:0] op_onehot,
    input logic [DATA_W-1:0]   opnd_a,
    input logic [DATA_W-1:0]   opnd_b,
    input logic [DATA_W-1:0]   res,
    input logic                store_bit,
    input logic                flag_c,
    input logic                flag_h,
    input logic                flag_z,
    input logic                flag_n
);
    logic single;
    logic zn_op;
    assign single = ($countones(op_onehot) == 1);
    assign zn_op  = single && (op_onehot[OP_ADD] || op_onehot[OP_SUB] ||
                               op_onehot[OP_LOGIC] || op_onehot[OP_MOVE] ||
                               op_onehot[OP_RORC] || op_onehot[OP_ROLC]);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!flag_c && !flag_h && !flag_z && !flag_n));

    // R2: an add carries out exactly when the wrapped sum is below an operand
    assert_add_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_ADD]) |=> (flag_c == ($past(res) < $past(opnd_a))));

    assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_SUB]) |=> (flag_c == ($past(opnd_a) < $past(opnd_b))));

    assert_zero_sign_R4: assert property (@(posedge clk) disable iff (rst)
        zn_op |=> ((flag_z == ($past(res) == '0)) && (flag_n == $past(res[DATA_W-1]))));

    assert_set_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_SETC]) |=> (flag_c && flag_h && $stable(flag_z) && $stable(flag_n)));

    assert_clr_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_CLRC]) |=> (!flag_c && !flag_h && $stable(flag_z) && $stable(flag_n)));

    assert_inv_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_INVC]) |=> ((flag_c != $past(flag_c)) && $stable(flag_h)));

    assert_store_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_STC]) |-> (store_bit == flag_c));

    assert_store_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !op_onehot[OP_STC] |-> !store_bit);

    assert_rol_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_ROLC]) |=> ((flag_c == $past(opnd_a[DATA_W-1])) && $stable(flag_h)));

    assert_ror_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (single && op_onehot[OP_RORC]) |=> ((flag_c == $past(opnd_a[0])) && $stable(flag_h)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !single |=> ($stable(flag_c) && $stable(flag_h) && $stable(flag_z) && $stable(flag_n)));
endmodule

bind alu_flag_unit flag_unit_checker #(.DATA_W(DATA_W)) i_flag_chk (
    .clk       (clk),
    .rst       (rst),
    .op_onehot (op_onehot),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .res       (res),
    .store_bit (store_bit),
    .flag_c    (flag_c),
    .flag_h    (flag_h),
    .flag_z    (flag_z),
    .flag_n    (flag_n)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
    localparam int B_ADD = 0, B_SUB = 1, B_LOGIC = 2, B_MOVE = 3, B_SETC = 4, B_CLRC = 5;
    localparam int B_INVC = 6, B_LDC = 7, B_STC = 8, B_RORC = 9, B_ROLC = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [10:0] op_onehot;
    logic [7:0] opnd_a, opnd_b, ext_res;
    logic       load_bit;
    logic [7:0] res;
    logic       store_bit, flag_c, flag_h, flag_z, flag_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model flags {c,h,z,n}
    logic m_c, m_h, m_z, m_n;
    logic [7:0] r_got;
    logic       sb_got;

    always #2.5 clk = ~clk;

    alu_flag_unit i_alu_flag_unit (
        .clk(clk), .rst(rst), .op_onehot(op_onehot), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .ext_res(ext_res), .load_bit(load_bit), .res(res), .store_bit(store_bit),
        .flag_c(flag_c), .flag_h(flag_h), .flag_z(flag_z), .flag_n(flag_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, {28'd0, flag_c, flag_h, flag_z, flag_n}, {28'd0, m_c, m_h, m_z, m_n});
    endtask

    function automatic logic [10:0] bit_of(input int i);
        return 11'(1) << i;
    endfunction

    task automatic apply(input logic [10:0] ops, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] ext, input logic lb);
        @(negedge clk);
        op_onehot = ops; opnd_a = a; opnd_b = b; ext_res = ext; load_bit = lb;
        #1;
        r_got  = res;
        sb_got = store_bit;
        @(posedge clk);
        #1;
        op_onehot = '0;
    endtask

    function automatic void zn_of(input logic [7:0] v);
        m_z = (v == 8'd0);
        m_n = v[7];
    endfunction

    task automatic test_reset();
        rst = 1'b1; op_onehot = '0; opnd_a = '0; opnd_b = '0; ext_res = '0; load_bit = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        m_c = 0; m_h = 0; m_z = 0; m_n = 0;
        chk_flags("R1 reset flags");
        @(negedge clk); rst = 1'b0;
        // set flags, then reset again mid-run
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        apply(bit_of(B_MOVE), 8'h00, 8'h00, 8'h80, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk_flags("R1 reset after activity");
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic test_add_sweep();
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                int s;
                s = a + b;
                apply(bit_of(B_ADD), 8'(a), 8'(b), 8'h00, 1'b0);
                m_c = s[8];
                m_h = ((a % 16) + (b % 16)) > 15;
                zn_of(8'(s));
                if (r_got !== 8'(s) || {flag_c, flag_h, flag_z, flag_n} !== {m_c, m_h, m_z, m_n}) begin
                    if (bad < 4) begin
                        chk("R2 add result", {24'd0, r_got}, {24'd0, 8'(s)});
                        chk_flags("R2 R4 add flags");
                    end
                    bad++;
                end
            end
        end
        chk("R2 add sweep mismatches", 32'(bad), 32'd0);
        // explicit corner: 0x0F + 0x01 half carry only; 0xFF + 0x01 wraps to zero
        apply(bit_of(B_ADD), 8'h0F, 8'h01, 8'h00, 1'b0);
        m_c = 0; m_h = 1; zn_of(8'h10);
        chk_flags("R2 nibble carry 0F+01");
        apply(bit_of(B_ADD), 8'hFF, 8'h01, 8'h00, 1'b0);
        m_c = 1; m_h = 1; zn_of(8'h00);
        chk_flags("R2 R4 wrap to zero FF+01");
    endtask

    task automatic test_sub_sweep();
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 7) begin
                logic [7:0] d;
                d = 8'(a - b);
                apply(bit_of(B_SUB), 8'(a), 8'(b), 8'h00, 1'b0);
                m_c = (a < b);
                m_h = ((a % 16) < (b % 16));
                zn_of(d);
                if (r_got !== d || {flag_c, flag_h, flag_z, flag_n} !== {m_c, m_h, m_z, m_n}) begin
                    if (bad < 4) begin
                        chk("R3 sub result", {24'd0, r_got}, {24'd0, d});
                        chk_flags("R3 R4 sub flags");
                    end
                    bad++;
                end
            end
        end
        chk("R3 sub sweep mismatches", 32'(bad), 32'd0);
        apply(bit_of(B_SUB), 8'h10, 8'h01, 8'h00, 1'b0);
        m_c = 0; m_h = 1; zn_of(8'h0F);
        chk_flags("R3 half borrow 10-01");
        apply(bit_of(B_SUB), 8'h42, 8'h42, 8'h00, 1'b0);
        m_c = 0; m_h = 0; zn_of(8'h00);
        chk_flags("R3 equal operands");
        apply(bit_of(B_SUB), 8'h00, 8'h01, 8'h00, 1'b0);
        m_c = 1; m_h = 1; zn_of(8'hFF);
        chk_flags("R3 borrow 00-01");
    endtask

    task automatic test_logic_move();
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1; m_h = 1;
        apply(bit_of(B_LOGIC), 8'h55, 8'h66, 8'h00, 1'b0);
        zn_of(8'h00);
        chk("R4 logic passes ext_res", {24'd0, r_got}, 32'd0);
        chk_flags("R4 logic zero keeps C H");
        apply(bit_of(B_MOVE), 8'h00, 8'h00, 8'hA5, 1'b0);
        zn_of(8'hA5);
        chk("R4 move passes ext_res", {24'd0, r_got}, 32'hA5);
        chk_flags("R4 move negative keeps C H");
        apply(bit_of(B_MOVE), 8'h00, 8'h00, 8'h01, 1'b0);
        zn_of(8'h01);
        chk_flags("R4 move positive nonzero");
    endtask

    task automatic test_set_clr();
        apply(bit_of(B_MOVE), 8'h00, 8'h00, 8'h80, 1'b0);
        m_z = 0; m_n = 1;
        apply(bit_of(B_CLRC), 8'hFF, 8'hFF, 8'h00, 1'b1);
        m_c = 0; m_h = 0;
        chk_flags("R5 clear carry and half");
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1; m_h = 1;
        chk_flags("R5 set carry and half, Z N held");
        chk("R10 res zero for set", {24'd0, r_got}, 32'd0);
    endtask

    task automatic test_inv_load();
        apply(bit_of(B_CLRC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0; m_h = 0;
        apply(bit_of(B_INVC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1;
        chk_flags("R6 invert 0 to 1");
        apply(bit_of(B_INVC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0;
        chk_flags("R6 invert 1 to 0");
        apply(bit_of(B_LDC), 8'h00, 8'h00, 8'h00, 1'b1);
        m_c = 1;
        chk_flags("R6 load 1");
        apply(bit_of(B_LDC), 8'hFF, 8'hFF, 8'h00, 1'b0);
        m_c = 0;
        chk_flags("R6 load 0");
    endtask

    task automatic test_store();
        apply(bit_of(B_LDC), 8'h00, 8'h00, 8'h00, 1'b1);
        m_c = 1;
        apply(bit_of(B_STC), 8'h00, 8'h00, 8'h00, 1'b0);
        chk("R7 store shows carry 1", {31'd0, sb_got}, 32'd1);
        chk_flags("R7 store leaves flags");
        apply(bit_of(B_CLRC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0; m_h = 0;
        apply(bit_of(B_STC), 8'h00, 8'h00, 8'h00, 1'b0);
        chk("R7 store shows carry 0", {31'd0, sb_got}, 32'd0);
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1; m_h = 1;
        apply(bit_of(B_INVC) | 11'd0, 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0;
        apply(bit_of(B_INVC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1;
        chk("R7 store_bit low without strobe", {31'd0, sb_got}, 32'd0);
    endtask

    task automatic test_rotate();
        // 16-bit value 0x8001 rotated left by one through the carry chain
        apply(bit_of(B_CLRC), 8'h00, 8'h00, 8'h00, 1'b0);
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1; m_h = 1;
        apply(bit_of(B_CLRC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0; m_h = 0;
        apply(bit_of(B_ROLC), 8'h01, 8'h00, 8'h00, 1'b0);
        m_c = 0; zn_of(8'h02);
        chk("R8 rol low byte", {24'd0, r_got}, 32'h02);
        chk_flags("R8 rol low flags");
        apply(bit_of(B_ROLC), 8'h80, 8'h00, 8'h00, 1'b0);
        m_c = 1; zn_of(8'h00);
        chk("R8 rol high byte", {24'd0, r_got}, 32'h00);
        chk_flags("R8 R4 rol high carry out zero");
        // rotate right 16-bit 0x0001 with carry in 1: high first
        apply(bit_of(B_RORC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 0; zn_of(8'h80);
        chk("R8 ror high takes carry in", {24'd0, r_got}, 32'h80);
        chk_flags("R8 ror high flags");
        apply(bit_of(B_RORC), 8'h01, 8'h00, 8'h00, 1'b0);
        m_c = 1; zn_of(8'h00);
        chk("R8 ror low byte", {24'd0, r_got}, 32'h00);
        chk_flags("R8 ror low carry out");
        // half carry held by rotate
        apply(bit_of(B_SETC), 8'h00, 8'h00, 8'h00, 1'b0);
        m_c = 1; m_h = 1;
        apply(bit_of(B_RORC), 8'hAA, 8'h00, 8'h00, 1'b0);
        m_c = 0; zn_of(8'hD5);
        chk("R8 ror AA with carry", {24'd0, r_got}, 32'hD5);
        chk_flags("R8 ror keeps half carry");
    endtask

    task automatic test_idle_invalid();
        apply(bit_of(B_MOVE), 8'h00, 8'h00, 8'h90, 1'b0);
        zn_of(8'h90);
        apply(11'd0, 8'hFF, 8'h01, 8'h00, 1'b1);
        chk_flags("R9 no strobe holds");
        apply(bit_of(B_CLRC) | bit_of(B_ADD), 8'hFF, 8'h01, 8'h00, 1'b0);
        chk_flags("R9 two strobes ignored");
        apply(bit_of(B_INVC) | bit_of(B_LDC) | bit_of(B_ROLC), 8'hFF, 8'h00, 8'h00, 1'b0);
        chk_flags("R9 three strobes ignored");
        apply(11'h7FF, 8'h00, 8'h00, 8'h00, 1'b0);
        chk_flags("R9 all strobes ignored");
        // R10: flags hold across idle cycles
        repeat (3) @(posedge clk);
        #1;
        chk_flags("R10 flags stable while idle");
    endtask

    initial begin
        test_reset();
        test_add_sweep();
        test_sub_sweep();
        test_logic_move();
        test_set_clr();
        test_inv_load();
        test_store();
        test_rotate();
        test_idle_invalid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule